// File: doc/BRIEF.md
# Indirect Mode-Register Host Bus Front End

This block is the register front end of a peripheral on a shared, byte-wide host bus. The bus has an active-low chip select, a read/write strobe and a single address line. A cycle with the address line low reaches a small mode register. A cycle with the address line high reaches one of three data registers, chosen by a two-bit selector field held in the mode register. All bus control and data inputs are sampled by the block's own clock through two flip-flop stages. Each write is committed once, when the synchronised chip select returns high.

The block also owns one request line on a shared, wired-OR interrupt line. It never drives the line high. It only asks for the line to be pulled low while an interrupt is pending. External logic raises the interrupt with a rising edge on a set input, and only while the mode register's enable bit is set. Any read or write of the mode register acknowledges the interrupt. Reset leaves the block disabled with the request released, so a line shared with other devices is never falsely asserted.

Top module: `hbif_top`

## Requirements
- R1: After reset the mode register and all three data registers are zero (block disabled), irq_pull is 0, hb_oe is 0 and hb_rdata is 0.
- R2: A write with hb_a1=0 loads the mode register: bits [1:0] are the selector, bit 2 is the enable bit, bit 3 is a spare control bit. A read with hb_a1=0 returns {4'b0000, bits[3:0]}.
- R3: A write with hb_a1=1 loads the data register chosen by the selector (0, 1 or 2). A read with hb_a1=1 returns that register, and the other data registers are left unchanged.
- R4: With selector value 3, a read with hb_a1=1 returns 0 and a write with hb_a1=1 changes no data register.
- R5: hb_oe is 1 only while the synchronised chip select is low and hb_rd is 1. Otherwise hb_oe is 0 and hb_rdata is 0.
- R6: With the enable bit set, a rising edge on irq_set makes irq_pull 1. irq_pull stays 1 across data-register accesses.
- R7: With the enable bit clear, a rising edge on irq_set is ignored and irq_pull stays 0.
- R8: Any completed read or write of the mode register clears irq_pull.
- R9: When a mode-register access completes in the same cycle that an irq_set edge is taken, the clear wins and irq_pull stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| hb_a1 | input | 1 | 0 = mode register, 1 = selected data register |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Read data, zero when not driven |
| hb_oe | output | 1 | Read-data output enable |
| irq_set | input | 1 | Interrupt set request, taken on its rising edge |
| irq_pull | output | 1 | 1 = pull the shared active-low interrupt line low |

## Verification
A stimulus table walks every selector value with distinct data patterns (A5, 3C, FF and a spare-bit mode). Each write is followed by a read through the same selector. This shows that decoding reaches the right register. It also shows that selector 3 both reads as zero and leaves the earlier registers intact. The interrupt is exercised in four ways: a set with the block enabled, a set with it disabled, data-register accesses that must not clear it, and read and write mode accesses that must clear it. A final case lines up a mode-register access with a set edge to show that the clear has priority.

// File: rtl/hbif_pkg.sv
package hbif_pkg;

    localparam int DATA_W   = 8;
    localparam int SEL_W    = 2;
    localparam int NUM_DATA = 3;
    localparam int MODE_W   = SEL_W + 2;

    typedef struct packed {
        logic              cs_n;
        logic              rd;
        logic              a1;
        logic [DATA_W-1:0] data;
    } hbus_t;

    localparam int HBUS_W = $bits(hbus_t);

    localparam hbus_t HBUS_IDLE = '{cs_n: 1'b1, rd: 1'b0, a1: 1'b0, data: '0};

    typedef struct packed {
        logic             spare;
        logic             en;
        logic [SEL_W-1:0] sel;
    } mode_t;

    function automatic mode_t byte_to_mode(input logic [DATA_W-1:0] b);
        mode_t m;
        m = mode_t'(b[MODE_W-1:0]);
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_byte(input mode_t m);
        return {{(DATA_W-MODE_W){1'b0}}, m};
    endfunction

endpackage

// File: rtl/hbif_sync.sv
module hbif_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hbif_regs.sv
module hbif_regs
    import hbif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              wr_a1,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_a1,
    output logic [DATA_W-1:0] rd_data,
    output mode_t             mode_q,
    output logic [NUM_DATA-1:0] data_we
);
    logic [DATA_W-1:0] data_q [NUM_DATA];
    logic [DATA_W-1:0] sel_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_stb && !wr_a1) begin
            mode_q <= byte_to_mode(wr_data);
        end
    end

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_data
        assign data_we[i] = wr_stb && wr_a1 && (int'(mode_q.sel) == i);

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[i] <= '0;
            end else if (data_we[i]) begin
                data_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (int'(mode_q.sel) == i) begin
                sel_data = data_q[i];
            end
        end
        rd_data = rd_a1 ? sel_data : mode_to_byte(mode_q);
    end
endmodule

// File: rtl/hbif_irq.sv
module hbif_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_edge,
    input  logic enable,
    input  logic ack,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (ack || !enable) begin
            pending <= 1'b0;
        end else if (set_edge) begin
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/hbif_top.sv
module hbif_top
    import hbif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hb_cs_n,
    input  logic              hb_rd,
    input  logic              hb_a1,
    input  logic [DATA_W-1:0] hb_wdata,
    output logic [DATA_W-1:0] hb_rdata,
    output logic              hb_oe,
    input  logic              irq_set,
    output logic              irq_pull
);
    hbus_t bus_raw, bus_cur, bus_prev;
    logic  set_cur, set_prev;
    logic  cyc_end, mode_access, wr_stb, set_edge;
    logic [DATA_W-1:0] reg_rdata;
    mode_t mode_q;
    logic [NUM_DATA-1:0] data_we;

    assign bus_raw = '{cs_n: hb_cs_n, rd: hb_rd, a1: hb_a1, data: hb_wdata};

    hbif_sync #(.W(HBUS_W), .RST_VAL(HBUS_IDLE)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_raw),
        .q   (bus_cur)
    );

    hbif_sync #(.W(1), .RST_VAL(1'b0)) u_irq_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_set),
        .q   (set_cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_prev <= HBUS_IDLE;
            set_prev <= 1'b0;
        end else begin
            bus_prev <= bus_cur;
            set_prev <= set_cur;
        end
    end

    assign cyc_end     = bus_cur.cs_n && !bus_prev.cs_n;
    assign mode_access = cyc_end && !bus_prev.a1;
    assign wr_stb      = cyc_end && !bus_prev.rd;
    assign set_edge    = set_cur && !set_prev;

    hbif_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_a1   (bus_prev.a1),
        .wr_data (bus_prev.data),
        .rd_a1   (bus_cur.a1),
        .rd_data (reg_rdata),
        .mode_q  (mode_q),
        .data_we (data_we)
    );

    hbif_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_edge (set_edge),
        .enable   (mode_q.en),
        .ack      (mode_access),
        .pending  (irq_pull)
    );

    assign hb_oe    = !bus_cur.cs_n && bus_cur.rd;
    assign hb_rdata = hb_oe ? reg_rdata : '0;
endmodule

// File: rtl/hbif_checker.sv
module hbif_checker (
    input logic       clk,
    input logic       rst,
    input logic       hb_cs_n,
    input logic       hb_rd,
    input logic       hb_oe,
    input logic [7:0] hb_rdata,
    input logic       irq_pull,
    input logic       en_q,
    input logic [1:0] sel_q,
    input logic       mode_access,
    input logic       set_edge,
    input logic [2:0] data_we
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!irq_pull && !hb_oe && hb_rdata == 8'h00));

    assert_sel3_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_q == 2'd3) |-> (data_we == 3'b000));

    assert_single_target_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(data_we));

    assert_oe_follows_bus_R5: assert property (@(posedge clk) disable iff (rst)
        hb_oe |-> (!$past(hb_cs_n, 2) && $past(hb_rd, 2)));

    assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !hb_oe |-> (hb_rdata == 8'h00));

    assert_set_when_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        (set_edge && en_q && !mode_access) |=> irq_pull);

    assert_set_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pull) |-> $past(en_q));

    assert_mode_access_clears_R8_R9: assert property (@(posedge clk) disable iff (rst)
        mode_access |=> !irq_pull);
endmodule

bind hbif_top hbif_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .hb_cs_n     (hb_cs_n),
    .hb_rd       (hb_rd),
    .hb_oe       (hb_oe),
    .hb_rdata    (hb_rdata),
    .irq_pull    (irq_pull),
    .en_q        (mode_q.en),
    .sel_q       (mode_q.sel),
    .mode_access (mode_access),
    .set_edge    (set_edge),
    .data_we     (data_we)
);

// File: tb/hbif_top_bench.sv
module hbif_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hb_cs_n = 1'b1;
    logic       hb_rd = 1'b0;
    logic       hb_a1 = 1'b0;
    logic [7:0] hb_wdata = 8'h00;
    logic [7:0] hb_rdata;
    logic       hb_oe;
    logic       irq_set = 1'b0;
    logic       irq_pull;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hbif_top u_hbif_top (
        .clk      (clk),
        .rst      (rst),
        .hb_cs_n  (hb_cs_n),
        .hb_rd    (hb_rd),
        .hb_a1    (hb_a1),
        .hb_wdata (hb_wdata),
        .hb_rdata (hb_rdata),
        .hb_oe    (hb_oe),
        .irq_set  (irq_set),
        .irq_pull (irq_pull)
    );

    // {mode byte, data byte, expected readback with A1=1}
    localparam logic [23:0] VEC [6] = '{
        {8'h04, 8'hA5, 8'hA5},   // R3 selector 0
        {8'h05, 8'h3C, 8'h3C},   // R3 selector 1
        {8'h06, 8'hFF, 8'hFF},   // R3 selector 2
        {8'h07, 8'h77, 8'h00},   // R4 selector 3
        {8'h0C, 8'h5A, 8'h5A},   // R3 selector 0, spare bit set
        {8'h09, 8'h81, 8'h81}    // R3 selector 1, disabled
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic a1, input logic [7:0] d);
        @(negedge clk);
        hb_a1 = a1; hb_rd = 1'b0; hb_wdata = d; hb_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        hb_cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic host_read(input logic a1, output logic [7:0] d, output logic oe);
        @(negedge clk);
        hb_a1 = a1; hb_rd = 1'b1; hb_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        d  = hb_rdata;
        oe = hb_oe;
        hb_cs_n = 1'b1;
        repeat (5) @(negedge clk);
        hb_rd = 1'b0;
    endtask

    task automatic pulse_set();
        @(negedge clk);
        irq_set = 1'b1;
        repeat (3) @(negedge clk);
        irq_set = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       oe;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 irq_pull", {7'd0, irq_pull}, 8'h00);
        chk("R1 hb_oe", {7'd0, hb_oe}, 8'h00);
        chk("R1 hb_rdata", hb_rdata, 8'h00);
        host_read(1'b0, rd, oe);
        chk("R1 mode after reset", rd, 8'h00);
        host_read(1'b1, rd, oe);
        chk("R1 data reg 0 after reset", rd, 8'h00);

        // R5 output enable while reading
        chk("R5 oe during read", {7'd0, oe}, 8'h01);

        // table walk for R2, R3, R4
        foreach (VEC[i]) begin
            host_write(1'b0, VEC[i][23:16]);
            host_read(1'b0, rd, oe);
            chk("R2 mode readback", rd, {4'h0, VEC[i][19:16]});
            host_write(1'b1, VEC[i][15:8]);
            host_read(1'b1, rd, oe);
            chk((VEC[i][17:16] == 2'd3) ? "R4 sel3 read" : "R3 data readback", rd, VEC[i][7:0]);
        end

        // R4: selector 3 write left earlier registers intact
        host_write(1'b0, 8'h02);
        host_read(1'b1, rd, oe);
        chk("R4 reg2 untouched by sel3 write", rd, 8'hFF);
        host_write(1'b0, 8'h00);
        host_read(1'b1, rd, oe);
        chk("R3 reg0 holds last write", rd, 8'h5A);

        // R2 upper bits dropped
        host_write(1'b0, 8'hF1);
        host_read(1'b0, rd, oe);
        chk("R2 upper bits read zero", rd, 8'h01);

        // R5 no drive during a write cycle or when idle
        @(negedge clk);
        hb_a1 = 1'b1; hb_rd = 1'b0; hb_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 oe during write", {7'd0, hb_oe}, 8'h00);
        chk("R5 rdata during write", hb_rdata, 8'h00);
        hb_cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R5 oe idle", {7'd0, hb_oe}, 8'h00);

        // R7 disabled: set ignored
        host_write(1'b0, 8'h00);
        pulse_set();
        chk("R7 set ignored when disabled", {7'd0, irq_pull}, 8'h00);

        // R6 enabled: set taken, survives data access
        host_write(1'b0, 8'h04);
        pulse_set();
        chk("R6 set when enabled", {7'd0, irq_pull}, 8'h01);
        host_write(1'b1, 8'h11);
        host_read(1'b1, rd, oe);
        chk("R6 held across data access", {7'd0, irq_pull}, 8'h01);

        // R8 mode read clears
        host_read(1'b0, rd, oe);
        chk("R8 cleared by mode read", {7'd0, irq_pull}, 8'h00);

        // R8 mode write clears (enable kept)
        pulse_set();
        chk("R6 set again", {7'd0, irq_pull}, 8'h01);
        host_write(1'b0, 8'h04);
        chk("R8 cleared by mode write", {7'd0, irq_pull}, 8'h00);

        // R9 coincident clear and set edge: clear wins
        @(negedge clk);
        hb_a1 = 1'b0; hb_rd = 1'b1; hb_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        hb_cs_n = 1'b1;
        irq_set = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 clear beats set", {7'd0, irq_pull}, 8'h00);
        irq_set = 1'b0;
        hb_rd = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset again clears pending interrupt and mode
        pulse_set();
        chk("R6 set before reset", {7'd0, irq_pull}, 8'h01);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq released by reset", {7'd0, irq_pull}, 8'h00);
        host_read(1'b0, rd, oe);
        chk("R1 mode cleared by reset", rd, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule